// File: doc/BRIEF.md
# Slot Hotplug Register Controller

This block keeps the hotplug bookkeeping for a row of expansion slots (32 by default) and shows it to software through four 32-bit registers on a simple select/write strobe bus. The platform side sends a pulse for each device insertion and for each removal request. The platform also drives two level masks: which slots are occupied, and which slots hold a fixed (non-hotpluggable) device. Software reads which slots should be checked for a device, reads which slots have a removal pending, and sees which slots may be removed at all. It acknowledges a removal by writing to the eject register. Each eject is passed on to the platform as a one-cycle release pulse that carries the slot index.

The "up" register is not stored. It is formed on every read as the present mask ANDed with the removable mask. A slot whose presence is reported more than once does no harm. Hot events set bit 1 (value 0x02) of a small event status register. That bit stays set until the platform clears it.

A platform reset request first completes every pending removal through the normal eject path, one slot per clock. It then rebuilds the removable mask and the present mask from the platform masks. During this sequence the block holds `busy` high and stalls the bus. The asynchronous reset performs the rebuild step only.

Top module: `slot_hp_regs`

## Requirements
- R1: A read at word index 0 (byte offset 0x00) returns the present mask ANDed with the removable mask.
- R2: A read at word index 1 (offset 0x04) returns the pending-removal mask. Writes at word indices 0, 1 and 3 change no register and produce no release pulse.
- R3: A write at word index 2 (offset 0x08) ejects only the slot of the lowest set bit of the write data. It clears that slot's pending-removal bit, and in the next cycle `rel_vld` is high for exactly one cycle with `rel_slot` equal to the slot number. A write of zero produces no pulse and changes nothing.
- R4: An eject clears the slot's present bit only when `slot_fixed` for that slot is 0. Otherwise the present bit stays set.
- R5: A read at word index 2 returns zero. A read at word index 3 (offset 0x0C) returns the removable mask.
- R6: A hot insertion (`ins_vld` with `ins_cold`=0) sets the slot's present bit. A removal request (`rm_vld`) sets the slot's pending-removal bit. Each of these sets `gpe_sts` bit 1 (value 0x02). A `gpe_clr` bit that is 1 clears the matching status bit, and a new event in the same cycle wins over the clear.
- R7: A cold insertion (`ins_vld` with `ins_cold`=1) sets the present bit and leaves `gpe_sts` unchanged.
- R8: A pulse on `rst_req` starts a drain. The drain ejects the lowest pending slot on each clock, with a release pulse for each, until the pending mask is empty. The rebuild step then loads the removable mask with the inverse of `slot_fixed` and the present mask with `slot_occupied`. `busy` is high and `bus_ready` is low for the whole sequence.
- R9: While `rst_n` is low, the pending mask, the event status, `rel_vld` and the masks are cleared. After release, `busy` is high for one cycle while the masks are rebuilt as in R8.
- R10: In a cycle where an eject and a new event hit the same slot, the event wins. An insertion keeps the present bit set, and a removal request keeps the pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 1 | Device insertion pulse |
| ins_slot | input | 5 | Slot of the insertion |
| ins_cold | input | 1 | Insertion is a boot-time (cold) plug |
| rm_vld | input | 1 | Removal request pulse |
| rm_slot | input | 5 | Slot of the removal request |
| slot_occupied | input | 32 | Platform mask of occupied slots, used by the rebuild |
| slot_fixed | input | 32 | Platform mask of slots holding fixed devices |
| rst_req | input | 1 | Platform reset request: drain, then rebuild |
| gpe_clr | input | 8 | Clear mask for the event status register |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register word index (byte offset bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted in this cycle |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| rel_vld | output | 1 | One-cycle slot release pulse |
| rel_slot | output | 5 | Slot to release |
| gpe_sts | output | 8 | Event status register |
| busy | output | 1 | Drain or rebuild in progress |

## Verification
The assertions check several properties on every cycle. Every release pulse must trace back to a nonzero eject write or to a drain cycle, and a write of zero must never give a pulse. A released slot's pending bit must be clear unless a removal request arrived in the same cycle. A fixed slot must keep its present bit through an eject. The bus must stall while busy, the feature register must read zero, and cold plugs must leave the status bit alone. Other behaviours are shown only by the bench scenarios: the value of the masked presence read, the choice of the lowest set bit out of several, the ignored writes, the order of the drain and the masks rebuilt after it, and the same-cycle conflicts.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic [1:0] {
    REG_UP    = 2'd0,
    REG_DOWN  = 2'd1,
    REG_EJECT = 2'd2,
    REG_RMV   = 2'd3
  } hp_reg_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_REBUILD = 2'd2
  } hp_state_e;

  localparam int GPE_W       = 8;
  localparam int GPE_HP_BIT  = 1;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int N  = 32,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [N-1:0]  onehot,
  output logic [SW-1:0] idx
);
  logic [N-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below[i] = below[i-1] | vec[i-1];
  end

  assign onehot = vec & ~below;
  assign found  = |vec;

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (onehot[k]) idx = idx | SW'(k);
    end
  end
endmodule

// File: rtl/hp_bus_dec.sv
module hp_bus_dec #(
  parameter int N = 32
) (
  input  logic         sel,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic         busy,
  input  logic [N-1:0] present,
  input  logic [N-1:0] enable,
  input  logic [N-1:0] down,
  output logic         ready,
  output logic [N-1:0] rdata,
  output logic         eject_we
);
  import hp_pkg::*;

  hp_reg_e reg_sel;

  assign reg_sel  = hp_reg_e'(addr);
  assign ready    = sel & ~busy;
  assign eject_we = ready & wr & (reg_sel == REG_EJECT);

  always_comb begin
    rdata = '0;
    unique case (reg_sel)
      REG_UP:    rdata = present & enable;
      REG_DOWN:  rdata = down;
      REG_EJECT: rdata = '0;
      REG_RMV:   rdata = enable;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ins_set,
  input  logic [N-1:0] rm_set,
  input  logic [N-1:0] ej_oh,
  input  logic [N-1:0] fixed,
  input  logic [N-1:0] occupied,
  input  logic         rebuild,
  output logic [N-1:0] present,
  output logic [N-1:0] down,
  output logic [N-1:0] enable
);
  logic [N-1:0] present_q, present_n;
  logic [N-1:0] down_q, down_n;
  logic [N-1:0] enable_q, enable_n;
  logic         upd_en;

  assign upd_en = rebuild | (|ins_set) | (|rm_set) | (|ej_oh);

  always_comb begin
    if (rebuild) begin
      present_n = occupied;
      enable_n  = ~fixed;
    end else begin
      present_n = (present_q & ~(ej_oh & ~fixed)) | ins_set;
      enable_n  = enable_q;
    end
    down_n = (down_q & ~ej_oh) | rm_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
      down_q    <= '0;
      enable_q  <= '0;
    end else if (upd_en) begin
      present_q <= present_n;
      down_q    <= down_n;
      enable_q  <= enable_n;
    end
  end

  assign present = present_q;
  assign down    = down_q;
  assign enable  = enable_q;
endmodule

// File: rtl/slot_hp_regs.sv
module slot_hp_regs #(
  parameter int NSLOT = 32,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ins_vld,
  input  logic [SW-1:0]          ins_slot,
  input  logic                   ins_cold,
  input  logic                   rm_vld,
  input  logic [SW-1:0]          rm_slot,
  input  logic [NSLOT-1:0]       slot_occupied,
  input  logic [NSLOT-1:0]       slot_fixed,
  input  logic                   rst_req,
  input  logic [hp_pkg::GPE_W-1:0] gpe_clr,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [1:0]             bus_addr,
  input  logic [NSLOT-1:0]       bus_wdata,
  output logic                   bus_ready,
  output logic [NSLOT-1:0]       bus_rdata,
  output logic                   rel_vld,
  output logic [SW-1:0]          rel_slot,
  output logic [hp_pkg::GPE_W-1:0] gpe_sts,
  output logic                   busy
);
  import hp_pkg::*;

  localparam logic [NSLOT-1:0]  ONE     = NSLOT'(1);
  localparam logic [GPE_W-1:0]  GPE_HIT = GPE_W'(1) << GPE_HP_BIT;

  hp_state_e      state_q, state_n;
  logic [NSLOT-1:0] present_w, down_w, enable_w;
  logic [NSLOT-1:0] ins_set, rm_set, ej_src, ej_oh;
  logic             ej_found, eject_we, draining, rebuild;
  logic [SW-1:0]    ej_idx;
  logic             rel_vld_q, rel_vld_n;
  logic [SW-1:0]    rel_slot_q, rel_slot_n;
  logic [GPE_W-1:0] gpe_q, gpe_n;
  logic             hot_evt, gpe_en;

  // state sequencing
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:    if (rst_req) state_n = ST_DRAIN;
      ST_DRAIN:   if (down_w == '0) state_n = ST_REBUILD;
      ST_REBUILD: state_n = ST_IDLE;
      default:    state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_REBUILD;
    else        state_q <= state_n;
  end

  assign draining = (state_q == ST_DRAIN);
  assign rebuild  = (state_q == ST_REBUILD);
  assign busy     = (state_q != ST_IDLE);

  // platform events
  assign ins_set = ins_vld ? (ONE << ins_slot) : '0;
  assign rm_set  = rm_vld  ? (ONE << rm_slot)  : '0;

  hp_bus_dec #(.N(NSLOT)) u_dec (
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .busy     (busy),
    .present  (present_w),
    .enable   (enable_w),
    .down     (down_w),
    .ready    (bus_ready),
    .rdata    (bus_rdata),
    .eject_we (eject_we)
  );

  // eject source: pending mask while draining, else software write data
  assign ej_src = draining ? down_w : (eject_we ? bus_wdata : '0);

  hp_lowbit #(.N(NSLOT), .SW(SW)) u_pick (
    .vec    (ej_src),
    .found  (ej_found),
    .onehot (ej_oh),
    .idx    (ej_idx)
  );

  hp_slot_state #(.N(NSLOT)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_set  (ins_set),
    .rm_set   (rm_set),
    .ej_oh    (ej_oh),
    .fixed    (slot_fixed),
    .occupied (slot_occupied),
    .rebuild  (rebuild),
    .present  (present_w),
    .down     (down_w),
    .enable   (enable_w)
  );

  // release pulse
  always_comb begin
    rel_vld_n  = ej_found;
    rel_slot_n = ej_found ? ej_idx : rel_slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_vld_q  <= 1'b0;
      rel_slot_q <= '0;
    end else begin
      rel_vld_q  <= rel_vld_n;
      rel_slot_q <= rel_slot_n;
    end
  end

  // event status: set wins over clear
  assign hot_evt = (ins_vld & ~ins_cold) | rm_vld;
  assign gpe_en  = hot_evt | (|gpe_clr);

  always_comb begin
    gpe_n = (gpe_q & ~gpe_clr) | (hot_evt ? GPE_HIT : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gpe_q <= '0;
    else if (gpe_en) gpe_q <= gpe_n;
  end

  assign rel_vld  = rel_vld_q;
  assign rel_slot = rel_slot_q;
  assign gpe_sts  = gpe_q;
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int NSLOT = 32,
  parameter int SW    = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [NSLOT-1:0] bus_wdata,
  input logic             bus_ready,
  input logic [NSLOT-1:0] bus_rdata,
  input logic             ins_vld,
  input logic             ins_cold,
  input logic             rm_vld,
  input logic [SW-1:0]    rm_slot,
  input logic [NSLOT-1:0] slot_fixed,
  input logic             rel_vld,
  input logic [SW-1:0]    rel_slot,
  input logic [7:0]       gpe_sts,
  input logic             busy,
  input logic [NSLOT-1:0] present_w,
  input logic [NSLOT-1:0] down_w
);
  logic [NSLOT-1:0] fixed_d, present_d;
  logic             ej_wr_d, ej_zero_d, drain_d, rm_hit_d;
  logic [SW-1:0]    rm_slot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fixed_d   <= '0;
      present_d <= '0;
      ej_wr_d   <= 1'b0;
      ej_zero_d <= 1'b0;
      drain_d   <= 1'b0;
      rm_hit_d  <= 1'b0;
      rm_slot_d <= '0;
    end else begin
      fixed_d   <= slot_fixed;
      present_d <= present_w;
      ej_wr_d   <= bus_sel & bus_wr & bus_ready & (bus_addr == 2'd2) & (bus_wdata != '0);
      ej_zero_d <= bus_sel & bus_wr & bus_ready & (bus_addr == 2'd2) & (bus_wdata == '0);
      drain_d   <= busy;
      rm_hit_d  <= rm_vld;
      rm_slot_d <= rm_slot;
    end
  end

  AST_REL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> (ej_wr_d || drain_d)); // R3

  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_zero_d && !drain_d) |-> !rel_vld); // R3

  AST_REL_CLEARS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && !(rm_hit_d && rm_slot_d == rel_slot)) |-> !down_w[rel_slot]); // R3

  AST_FIXED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && fixed_d[rel_slot] && present_d[rel_slot]) |-> present_w[rel_slot]); // R4

  AST_FEATURE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_ready && bus_addr == 2'd2) |-> (bus_rdata == '0)); // R5

  AST_COLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && ins_cold && !rm_vld && !gpe_sts[1]) |=> !gpe_sts[1]); // R7

  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !bus_ready); // R8

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !rm_hit_d) |-> (down_w == '0)); // R8
endmodule

bind slot_hp_regs hp_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready),
  .bus_rdata  (bus_rdata),
  .ins_vld    (ins_vld),
  .ins_cold   (ins_cold),
  .rm_vld     (rm_vld),
  .rm_slot    (rm_slot),
  .slot_fixed (slot_fixed),
  .rel_vld    (rel_vld),
  .rel_slot   (rel_slot),
  .gpe_sts    (gpe_sts),
  .busy       (busy),
  .present_w  (present_w),
  .down_w     (down_w)
);

// File: tb/slot_hp_regs_test.sv
module slot_hp_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        ins_vld, ins_cold, rm_vld, rst_req;
  logic [4:0]  ins_slot, rm_slot;
  logic [31:0] slot_occupied, slot_fixed;
  logic [7:0]  gpe_clr;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        rel_vld;
  logic [4:0]  rel_slot;
  logic [7:0]  gpe_sts;
  logic        busy;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  slot_hp_regs uut (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_slot(ins_slot),
    .ins_cold(ins_cold), .rm_vld(rm_vld), .rm_slot(rm_slot),
    .slot_occupied(slot_occupied), .slot_fixed(slot_fixed), .rst_req(rst_req),
    .gpe_clr(gpe_clr), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .rel_vld(rel_vld), .rel_slot(rel_slot), .gpe_sts(gpe_sts), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // op codes of the vector table
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_HINS = 3'd2,
                         OP_CINS = 3'd3, OP_RM = 3'd4, OP_FIX = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  arg;   // word index or slot
    logic [31:0] data;
    logic [31:0] exp;   // read value, or release code 0x20|slot (0 = no pulse)
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0003, 8'd1}, // R1
    '{OP_RD,   5'd3, 32'h0,        32'hFFFF_FEFF, 8'd5}, // R5
    '{OP_RD,   5'd2, 32'h0,        32'h0,         8'd5}, // R5
    '{OP_HINS, 5'd5, 32'h0,        32'h0,         8'd6}, // R6
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0023, 8'd6}, // R6
    '{OP_RM,   5'd1, 32'h0,        32'h0,         8'd6}, // R6
    '{OP_RM,   5'd8, 32'h0,        32'h0,         8'd6}, // R6
    '{OP_RD,   5'd1, 32'h0,        32'h0000_0102, 8'd6}, // R6
    '{OP_WR,   5'd1, 32'hFFFF_FFFF,32'h0,         8'd2}, // R2
    '{OP_WR,   5'd0, 32'h0,        32'h0,         8'd2}, // R2
    '{OP_WR,   5'd3, 32'h0,        32'h0,         8'd2}, // R2
    '{OP_RD,   5'd1, 32'h0,        32'h0000_0102, 8'd2}, // R2
    '{OP_RD,   5'd3, 32'h0,        32'hFFFF_FEFF, 8'd2}, // R2
    '{OP_WR,   5'd2, 32'h0000_0106,32'h21,        8'd3}, // R3
    '{OP_RD,   5'd1, 32'h0,        32'h0000_0100, 8'd3}, // R3
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0021, 8'd1}, // R1
    '{OP_WR,   5'd2, 32'h0000_0100,32'h28,        8'd3}, // R3
    '{OP_RD,   5'd1, 32'h0,        32'h0,         8'd3}, // R3
    '{OP_FIX,  5'd0, 32'h0000_0104,32'h0,         8'd4}, // R4
    '{OP_HINS, 5'd2, 32'h0,        32'h0,         8'd4}, // R4
    '{OP_WR,   5'd2, 32'h0000_0004,32'h22,        8'd4}, // R4
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0025, 8'd4}, // R4
    '{OP_WR,   5'd2, 32'h0000_0020,32'h25,        8'd4}, // R4
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0005, 8'd4}, // R4
    '{OP_WR,   5'd2, 32'h0,        32'h0,         8'd3}, // R3
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0005, 8'd3}, // R3
    '{OP_CINS, 5'd9, 32'h0,        32'h0,         8'd7}, // R7
    '{OP_RD,   5'd0, 32'h0,        32'h0000_0205, 8'd7}, // R7
    '{OP_RD,   5'd1, 32'h0,        32'h0,         8'd2}  // R2
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d, output logic rdy);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; rdy = bus_ready;
    bus_sel = 1'b0;
  endtask

  // returns release code observed in the cycle after the write
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d, output logic [31:0] code);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    code = rel_vld ? (32'h20 | 32'(rel_slot)) : 32'h0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic plat_ins(input logic [4:0] s, input logic cold);
    @(negedge clk);
    ins_vld = 1'b1; ins_slot = s; ins_cold = cold;
    @(negedge clk);
    ins_vld = 1'b0; ins_cold = 1'b0;
  endtask

  task automatic plat_rm(input logic [4:0] s);
    @(negedge clk);
    rm_vld = 1'b1; rm_slot = s;
    @(negedge clk);
    rm_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, code;
    logic        rdy;
    int          npulse, nbusy, nstall;
    logic [4:0]  seq [3];

    rst_n = 1'b0; ins_vld = 0; ins_cold = 0; ins_slot = '0;
    rm_vld = 0; rm_slot = '0; rst_req = 0; gpe_clr = '0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    slot_occupied = 32'h0000_0103; slot_fixed = 32'h0000_0100;
    #(CLK_PERIOD * 3);
    // R9: reset state
    check(9, {30'd0, rel_vld, busy}, 32'h1);
    check(9, {24'd0, gpe_sts}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(9, {31'd0, busy}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      unique case (v.op)
        OP_RD: begin
          bus_read(v.arg[1:0], d, rdy);
          check(int'(v.req), d, v.exp);
        end
        OP_WR: begin
          bus_write(v.arg[1:0], v.data, code);
          check(int'(v.req), code, v.exp);
        end
        OP_HINS: plat_ins(v.arg, 1'b0);
        OP_CINS: plat_ins(v.arg, 1'b1);
        OP_RM:   plat_rm(v.arg);
        OP_FIX:  begin @(negedge clk); slot_fixed = v.data; end
        default: ;
      endcase
    end

    // R6: clear, then R7 cold quiet, then R6 hot sets 0x02
    @(negedge clk); gpe_clr = 8'hFF;
    @(negedge clk); gpe_clr = 8'h00;
    check(6, {24'd0, gpe_sts}, 32'h0);
    plat_ins(5'd10, 1'b1);
    check(7, {24'd0, gpe_sts}, 32'h0);   // R7
    plat_rm(5'd10);
    check(6, {24'd0, gpe_sts}, 32'h02);  // R6
    plat_rm(5'd0);

    // R10: removal and eject of slot 3 in the same cycle
    @(negedge clk);
    rm_vld = 1'b1; rm_slot = 5'd3;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h8;
    @(negedge clk);
    code = rel_vld ? (32'h20 | 32'(rel_slot)) : 32'h0;
    rm_vld = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    check(10, code, 32'h23);
    bus_read(2'd1, d, rdy);
    check(10, d, 32'h0000_0409);
    // R10: insertion and eject of slot 4 in the same cycle
    @(negedge clk);
    ins_vld = 1'b1; ins_slot = 5'd4; ins_cold = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h10;
    @(negedge clk);
    code = rel_vld ? (32'h20 | 32'(rel_slot)) : 32'h0;
    ins_vld = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    check(10, code, 32'h24);
    bus_read(2'd0, d, rdy);
    check(10, d, 32'h0000_0615);

    // R8: drain of slots 0, 3, 10 then rebuild
    @(negedge clk);
    slot_occupied = 32'h0000_0013; slot_fixed = 32'h0000_0010;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
    npulse = 0; nbusy = 0; nstall = 0;
    for (int c = 0; c < 20; c++) begin
      #1;
      if (!busy) break;
      nbusy++;
      if (bus_ready) nstall++;
      if (rel_vld) begin
        if (npulse < 3) seq[npulse] = rel_slot;
        npulse++;
      end
      @(negedge clk);
    end
    bus_sel = 1'b0;
    check(8, 32'(nbusy), 32'd5);
    check(8, 32'(nstall), 32'd0);
    check(8, 32'(npulse), 32'd3);
    check(8, {17'd0, seq[0], seq[1], seq[2]}, {17'd0, 5'd0, 5'd3, 5'd10});
    bus_read(2'd0, d, rdy);
    check(8, d, 32'h0000_0003);
    bus_read(2'd3, d, rdy);
    check(8, d, 32'hFFFF_FFEF);
    bus_read(2'd1, d, rdy);
    check(8, d, 32'h0);

    // R9: asynchronous reset mid-run
    plat_rm(5'd6);
    @(negedge clk); rst_n = 1'b0;
    #2;
    check(9, {24'd0, gpe_sts}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(9, {31'd0, busy}, 32'h1);
    @(negedge clk);
    check(9, {31'd0, busy}, 32'h0);
    bus_read(2'd1, d, rdy);
    check(9, d, 32'h0);
    bus_read(2'd0, d, rdy);
    check(9, d, 32'h0000_0003);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule